// File: doc/BRIEF.md
# Label-Switching Forwarding Controller

This block moves packets through a label-switching router with a parameterised number of ports (four by default). Every input port writes its 32-bit words into a private FIFO. A port takes a packet whenever its valid strobe is high and its busy flag is clear. A fixed-priority arbiter chooses one port with buffered data. The arbiter grants only while the controller is idle, and port 0 wins over higher indices.

The controller takes the label from the head word of the granted packet. It asks an external lookup agent for the replacement label and the egress port, and waits for the answer. On a hit it sends the rewritten header on the chosen egress port, then streams the rest of that FIFO one word per cycle until the FIFO is empty. On a miss it drains the packet silently. Each port's busy flag goes high with the first accepted word. The flag blocks any new packet on that port until the packet's last word has left the FIFO.

The controller has five states. IDLE moves to LOOKUP when the arbiter grants. LOOKUP moves to HDR when the answer is a hit, and to FLUSH when it is a miss. HDR moves to IDLE if the header was the last word, and to DRAIN otherwise. DRAIN and FLUSH both move to IDLE when the last word is read.

Top module: `lsr_fwd_ctrl`

## Requirements
- R1: While a port's busy flag is low, or while that port is still writing the packet that set it, a cycle with in_vld high stores that port's in_word slice in its FIFO. The stored words leave the FIFO in arrival order.
- R2: in_busy of a port rises only in the cycle after a word was written on that port. Once the packet's valid run has ended, further valid words on that port are discarded while in_busy stays high.
- R3: in_busy is low after reset. It falls in the cycle right after the packet's last word is read from the FIFO.
- R4: Grants follow fixed priority, with port 0 highest. When two ports fill in the same cycle, the lower-numbered port is looked up and served first.
- R5: lkp_label carries bits [31:12] of the packet's first word. lkp_req stays high with lkp_label stable until a cycle in which lkp_ack is high.
- R6: On a hit (lkp_hit=1 with lkp_ack), the next cycle sends the header on output lkp_port. The header has lkp_new_label in bits [31:12] and the first word's bits [11:0] unchanged.
- R7: After the header, the remaining words go out on the same output in order, one per cycle. The granted port is emptied before any other port is served, even if the other port targets the same output.
- R8: out_vld is one-hot or zero. out_last is high only with out_vld, and only on the final word of a packet.
- R9: On a miss (lkp_hit=0 with lkp_ack), the whole packet is drained and no output word is sent for it.
- R10: No output word is sent while a lookup is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_word | input | NPORT*DW | Input data, port i in slice [i*DW +: DW] |
| in_vld | input | NPORT | Per-port input word valid |
| in_busy | output | NPORT | Per-port packet held, new packet refused |
| lkp_req | output | 1 | Lookup request |
| lkp_label | output | LW | Label of the packet under lookup |
| lkp_ack | input | 1 | Lookup answer valid |
| lkp_hit | input | 1 | Label found in the table |
| lkp_new_label | input | LW | Replacement label |
| lkp_port | input | PW | Egress port index |
| out_word | output | NPORT*DW | Output data, port i in slice [i*DW +: DW] |
| out_vld | output | NPORT | Per-port output word valid |
| out_last | output | NPORT | Final word of the packet |

## Verification
Single packets of 1, 2, 3, 4, 5 and 16 words are sent from every source port. They map to every egress port, so both the header-only exit from HDR and long DRAIN runs occur. One of them misses, to show that FLUSH drops the packet without emitting anything. Two ports are filled in the same cycle with a shared egress port. That separates correct priority from reversed priority, and separates whole-FIFO service from interleaving. Holding the lookup answer back keeps the port busy, so a second packet can be offered and its refusal observed. The cycle in which busy falls is also checked against the cycle of the final output word.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_HDR,
        ST_DRAIN,
        ST_FLUSH
    } lsr_state_e;
endpackage

// File: rtl/lsr_port_fifo.sv
module lsr_port_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_vld,
    input  logic [DW-1:0] wr_data,
    input  logic          rd,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          rd_last,
    output logic          busy
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [AW:0]   cnt_q;
    logic          busy_q, open_q;
    logic          full, acc;

    assign full    = (cnt_q == (AW+1)'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign acc     = wr_vld && !full && (!busy_q || open_q);
    assign rd_last = (cnt_q == (AW+1)'(1)) && !acc;
    assign rd_data = mem[rptr_q];
    assign busy    = busy_q;

    always_ff @(posedge clk) begin
        if (acc) begin
            mem[wptr_q] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            open_q <= 1'b0;
        end else begin
            open_q <= acc;
            if (acc) begin
                wptr_q <= (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
            end
            if (rd) begin
                rptr_q <= (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
            end
            cnt_q <= cnt_q + (AW+1)'(acc) - (AW+1)'(rd);
            if (rd && rd_last) begin
                busy_q <= 1'b0;
            end else if (acc) begin
                busy_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lsr_prio_arb.sv
module lsr_prio_arb #(
    parameter int N = 4
) (
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        gnt = '0;
        if (en) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (req[i]) begin
                    gnt    = '0;
                    gnt[i] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lsr_fwd_ctrl.sv
module lsr_fwd_ctrl
    import lsr_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int LW    = 20,
    parameter int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPORT*DW-1:0] in_word,
    input  logic [NPORT-1:0]    in_vld,
    output logic [NPORT-1:0]    in_busy,
    output logic                lkp_req,
    output logic [LW-1:0]       lkp_label,
    input  logic                lkp_ack,
    input  logic                lkp_hit,
    input  logic [LW-1:0]       lkp_new_label,
    input  logic [PW-1:0]       lkp_port,
    output logic [NPORT*DW-1:0] out_word,
    output logic [NPORT-1:0]    out_vld,
    output logic [NPORT-1:0]    out_last
);
    localparam int KW = DW - LW;

    lsr_state_e    state_q, state_d;
    logic [PW-1:0] cur_q, dest_q, gidx;
    logic [LW-1:0] lbl_q;

    logic [DW-1:0]    head [NPORT];
    logic [NPORT-1:0] empty, last, pop, req, gnt;
    logic [DW-1:0]    cur_head;
    logic             cur_empty, cur_last, pop_cur;

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        lsr_port_fifo #(.DW(DW), .DEPTH(DEPTH)) i_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_vld  (in_vld[i]),
            .wr_data (in_word[i*DW +: DW]),
            .rd      (pop[i]),
            .rd_data (head[i]),
            .empty   (empty[i]),
            .rd_last (last[i]),
            .busy    (in_busy[i])
        );
    end

    assign req = ~empty;

    lsr_prio_arb #(.N(NPORT)) i_arb (
        .en  (state_q == ST_IDLE),
        .req (req),
        .gnt (gnt)
    );

    always_comb begin
        gidx      = '0;
        cur_head  = '0;
        cur_empty = 1'b1;
        cur_last  = 1'b0;
        for (int i = 0; i < NPORT; i++) begin
            if (gnt[i]) gidx = PW'(i);
            if (cur_q == PW'(i)) begin
                cur_head  = head[i];
                cur_empty = empty[i];
                cur_last  = last[i];
            end
        end
    end

    assign pop_cur = (state_q == ST_HDR) ||
                     (((state_q == ST_DRAIN) || (state_q == ST_FLUSH)) && !cur_empty);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (|gnt) state_d = ST_LOOKUP;
            ST_LOOKUP: if (lkp_ack) state_d = lkp_hit ? ST_HDR : ST_FLUSH;
            ST_HDR:    state_d = cur_last ? ST_IDLE : ST_DRAIN;
            ST_DRAIN,
            ST_FLUSH:  if (pop_cur && cur_last) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            dest_q  <= '0;
            lbl_q   <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_IDLE) && (|gnt)) begin
                cur_q <= gidx;
            end
            if ((state_q == ST_LOOKUP) && lkp_ack) begin
                dest_q <= lkp_port;
                lbl_q  <= lkp_new_label;
            end
        end
    end

    always_comb begin
        lkp_req   = (state_q == ST_LOOKUP);
        lkp_label = cur_head[DW-1 -: LW];
        out_word  = '0;
        out_vld   = '0;
        out_last  = '0;
        pop       = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (cur_q == PW'(i)) pop[i] = pop_cur;
            if (dest_q == PW'(i)) begin
                if (state_q == ST_HDR) begin
                    out_vld[i]             = 1'b1;
                    out_word[i*DW +: DW]   = {lbl_q, cur_head[KW-1:0]};
                    out_last[i]            = cur_last;
                end else if ((state_q == ST_DRAIN) && !cur_empty) begin
                    out_vld[i]             = 1'b1;
                    out_word[i*DW +: DW]   = cur_head;
                    out_last[i]            = cur_last;
                end
            end
        end
    end
endmodule

// File: rtl/lsr_fwd_chk.sv
module lsr_fwd_chk #(
    parameter int NPORT = 4,
    parameter int LW    = 20,
    parameter int PW    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPORT-1:0] in_vld,
    input logic [NPORT-1:0] in_busy,
    input logic             lkp_req,
    input logic [LW-1:0]    lkp_label,
    input logic             lkp_ack,
    input logic             lkp_hit,
    input logic [PW-1:0]    lkp_port,
    input logic [NPORT-1:0] out_vld,
    input logic [NPORT-1:0] out_last
);
    p_out_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_vld));

    p_last_needs_vld_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_last & ~out_vld) == '0);

    p_req_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_req && !lkp_ack) |=> (lkp_req && $stable(lkp_label)));

    p_quiet_lookup_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_req |-> (out_vld == '0));

    p_miss_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_req && lkp_ack && !lkp_hit) |=> (out_vld == '0));

    p_hdr_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_req && lkp_ack && lkp_hit) |=> (out_vld == (NPORT'(1) << $past(lkp_port))));

    for (genvar i = 0; i < NPORT; i++) begin : g_busy
        p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(in_busy[i]) |-> $past(in_vld[i]));
    end
endmodule

bind lsr_fwd_ctrl lsr_fwd_chk #(.NPORT(NPORT), .LW(LW), .PW(PW)) i_lsr_fwd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (in_vld),
    .in_busy   (in_busy),
    .lkp_req   (lkp_req),
    .lkp_label (lkp_label),
    .lkp_ack   (lkp_ack),
    .lkp_hit   (lkp_hit),
    .lkp_port  (lkp_port),
    .out_vld   (out_vld),
    .out_last  (out_last)
);

// File: tb/test_lsr_fwd_ctrl.sv
`timescale 1ns/1ps
module test_lsr_fwd_ctrl;
    localparam int NP = 4;
    localparam int DW = 32;
    localparam int LW = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NP*DW-1:0] in_word = '0;
    logic [NP-1:0]    in_vld = '0;
    logic [NP-1:0]    in_busy;
    logic             lkp_req;
    logic [LW-1:0]    lkp_label;
    logic             lkp_ack = 1'b0;
    logic             lkp_hit = 1'b0;
    logic [LW-1:0]    lkp_new_label = '0;
    logic [1:0]       lkp_port = '0;
    logic [NP*DW-1:0] out_word;
    logic [NP-1:0]    out_vld;
    logic [NP-1:0]    out_last;

    always #5 clk = ~clk;

    lsr_fwd_ctrl i_lsr_fwd_ctrl (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_vld(in_vld),
        .in_busy(in_busy), .lkp_req(lkp_req), .lkp_label(lkp_label),
        .lkp_ack(lkp_ack), .lkp_hit(lkp_hit), .lkp_new_label(lkp_new_label),
        .lkp_port(lkp_port), .out_word(out_word), .out_vld(out_vld),
        .out_last(out_last)
    );

    int errors = 0;
    int checks = 0;

    // lookup agent: hit unless label nibble is F; new label = label + 0x100;
    // egress port = label[1:0]
    logic          hold_ack = 1'b0;
    logic [LW-1:0] lk_log [32];
    int            nlk = 0;
    always @(negedge clk) begin
        if (lkp_req && !lkp_ack && !hold_ack) begin
            lkp_ack       <= 1'b1;
            lkp_hit       <= (lkp_label[3:0] != 4'hF);
            lkp_new_label <= lkp_label + 20'h100;
            lkp_port      <= lkp_label[1:0];
            if (nlk < 32) lk_log[nlk] = lkp_label;
            nlk = nlk + 1;
        end else begin
            lkp_ack <= 1'b0;
        end
    end

    // output monitor
    logic [DW-1:0] cap   [NP][64];
    logic          caplst[NP][64];
    int            ncap  [NP];
    initial for (int p = 0; p < NP; p++) ncap[p] = 0;
    always @(negedge clk) begin
        for (int p = 0; p < NP; p++) begin
            if (out_vld[p] && ncap[p] < 64) begin
                cap[p][ncap[p]]    = out_word[p*DW +: DW];
                caplst[p][ncap[p]] = out_last[p];
                ncap[p]            = ncap[p] + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pword(input int id, input int p,
                                          input logic [19:0] lbl, input int j);
        if (j == 0) return {lbl, 12'(id)};
        return {8'(id), 8'(p), 16'(j)};
    endfunction

    task automatic send_pkt(input int p, input logic [19:0] lbl, input int len,
                            input int id);
        for (int j = 0; j < len; j++) begin
            @(posedge clk); #2;
            in_vld[p]            = 1'b1;
            in_word[p*DW +: DW]  = pword(id, p, lbl, j);
        end
        @(posedge clk); #2;
        in_vld[p] = 1'b0;
    endtask

    task automatic wait_quiet();
        int k;
        for (k = 0; k < 400; k++) begin
            @(negedge clk);
            if (in_busy == '0 && !lkp_req && out_vld == '0) break;
        end
        chk(k < 400, "R3 drain finished", 32'(in_busy), 32'h0);
        repeat (2) @(negedge clk);
    endtask

    // check one forwarded packet in capture of output o starting at index b
    task automatic chk_pkt(input int o, input int b, input int p,
                           input logic [19:0] lbl, input int len, input int id);
        bit ok_w = 1;
        bit ok_l = 1;
        logic [31:0] a = '0, e = '0;
        for (int j = 0; j < len; j++) begin
            logic [31:0] ex = (j == 0) ? {lbl + 20'h100, 12'(id)} : pword(id, p, lbl, j);
            if (cap[o][b+j] !== ex && ok_w) begin ok_w = 0; a = cap[o][b+j]; e = ex; end
            if (caplst[o][b+j] !== (j == len - 1)) ok_l = 0;
        end
        chk(ok_w, "R6/R7 forwarded words", a, e);
        chk(ok_l, "R8 last flag position", 32'(id), 32'(len));
    endtask

    // vector: src port(4) | label(20) | length(8) | id(8)
    localparam logic [39:0] VEC [6] = '{
        {4'd0, 20'h00012, 8'd4,  8'd1},
        {4'd1, 20'h00101, 8'd1,  8'd2},
        {4'd2, 20'h00A03, 8'd16, 8'd3},
        {4'd3, 20'h00020, 8'd3,  8'd4},
        {4'd3, 20'h0003F, 8'd5,  8'd5},
        {4'd0, 20'h12345, 8'd2,  8'd6}
    };

    bit done = 0;
    int base [NP];
    int tot0, lk0;

    initial begin
        repeat (3) @(negedge clk);
        chk(in_busy == '0, "R3 busy low in reset", 32'(in_busy), 0);
        chk(out_vld == '0 && !lkp_req, "R10 idle outputs in reset", 32'(out_vld), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table walk: R1 R5 R6 R7 R8 R9
        for (int v = 0; v < 6; v++) begin
            int p   = int'(VEC[v][39:36]);
            logic [19:0] lbl = VEC[v][35:16];
            int len = int'(VEC[v][15:8]);
            int id  = int'(VEC[v][7:0]);
            int o   = int'(lbl[1:0]);
            bit hit = (lbl[3:0] != 4'hF);
            for (int q = 0; q < NP; q++) base[q] = ncap[q];
            tot0 = ncap[0] + ncap[1] + ncap[2] + ncap[3];
            lk0  = nlk;
            send_pkt(p, lbl, len, id);
            wait_quiet();
            chk(nlk == lk0 + 1 && lk_log[lk0] == lbl, "R5 lookup label",
                32'(lk_log[lk0]), 32'(lbl));
            if (hit) begin
                chk(ncap[o] - base[o] == len, "R1/R7 word count",
                    32'(ncap[o] - base[o]), 32'(len));
                chk_pkt(o, base[o], p, lbl, len, id);
            end else begin
                chk(ncap[0] + ncap[1] + ncap[2] + ncap[3] == tot0, "R9 miss emits nothing",
                    32'(ncap[0] + ncap[1] + ncap[2] + ncap[3] - tot0), 0);
            end
        end

        // R4 / R7: ports 2 and 1 filled together, same egress port 1
        base[1] = ncap[1];
        lk0 = nlk;
        fork
            send_pkt(2, 20'h00205, 3, 20);
            send_pkt(1, 20'h00111, 3, 21);
        join
        wait_quiet();
        chk(lk_log[lk0] == 20'h00111, "R4 lower port first", 32'(lk_log[lk0]), 32'h111);
        chk(lk_log[lk0+1] == 20'h00205, "R4 higher port next", 32'(lk_log[lk0+1]), 32'h205);
        chk(ncap[1] - base[1] == 6, "R7 both packets out", 32'(ncap[1] - base[1]), 6);
        chk_pkt(1, base[1], 1, 20'h00111, 3, 21);
        chk_pkt(1, base[1] + 3, 2, 20'h00205, 3, 20);

        // R2 / R10: held lookup keeps port busy, second packet refused
        hold_ack = 1'b1;
        base[2] = ncap[2];
        lk0 = nlk;
        send_pkt(0, 20'h00302, 2, 30);
        repeat (3) @(negedge clk);
        chk(in_busy[0] == 1'b1, "R2 busy while held", 32'(in_busy), 1);
        chk(lkp_req && out_vld == '0, "R10 no output during lookup", 32'(out_vld), 0);
        send_pkt(0, 20'h00403, 3, 31);
        @(negedge clk);
        chk(in_busy[0] == 1'b1, "R2 busy still high", 32'(in_busy), 1);
        hold_ack = 1'b0;
        wait_quiet();
        chk(ncap[2] - base[2] == 2, "R2 refused packet not stored",
            32'(ncap[2] - base[2]), 2);
        chk(nlk == lk0 + 1, "R2 single lookup", 32'(nlk - lk0), 1);
        chk_pkt(2, base[2], 0, 20'h00302, 2, 30);

        // R3: busy falls the cycle after the final word is read
        send_pkt(3, 20'h00010, 1, 40);
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (out_vld[0]) break;
        end
        chk(out_last[0] && in_busy[3], "R3 busy high with last word",
            {30'h0, out_last[0], in_busy[3]}, 32'h3);
        @(negedge clk);
        chk(!in_busy[3], "R3 busy low next cycle", 32'(in_busy[3]), 0);
        wait_quiet();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule